// File: doc/BRIEF.md
# Saturating Wiper Tap Switch Decoder

This block sits between the latched wiper code of a digitally programmed resistor ladder and the analog switches of that ladder. On every clock it turns the code and a shutdown request into a one-hot vector that closes exactly one tap switch. It also drives two end-terminal controls: one closes the switch to the A end of the ladder, and one shorts the wiper to the B end.

Position 0 is the B end of the ladder. Each step up in code moves the wiper one tap toward A. The code width and the number of positions are parameters. The default is a 6-bit code driving 33 taps. Codes above the top tap saturate onto that tap. Setting an 8-bit code with 256 positions gives the full-range variant, where no saturation occurs.

While shutdown is held, the A switch opens and the wiper is shorted to B, whatever the code. When shutdown is released, the tap follows the code again. All outputs are registered and move together on a single clock edge. A position output reports the effective tap index.

Top module: `wiper_tap_switch_dec`

## Requirements
- R1: While reset is asserted and until the first clock after it, only tap enable bit 0 is high, the A-switch enable is low, the wiper-to-B short is high and the position output is 0.
- R2: With shutdown low and a code below NUM_POS-1, the clock edge that samples them sets tap enable bit number `code` (bit 0 is the B end) and sets the position output to `code`.
- R3: With shutdown low and a code at or above NUM_POS-1 (with defaults: codes 32 to 63), the selected tap and the position output are NUM_POS-1.
- R4: With shutdown high, the next outputs are: only tap bit 0 high, A-switch enable low, wiper-to-B short high, position 0, for any code.
- R5: With shutdown low, the next outputs have the A-switch enable high and the wiper-to-B short low.
- R6: Exactly one tap enable bit is high in every cycle after reset.
- R7: In the first cycle after shutdown is released, the outputs follow the code present at that moment, and not the code held during shutdown.
- R8: The outputs change only at a rising clock edge. A new input affects no output before the next edge, and all outputs take their new values at that same edge.
- R9: The position output always equals the index of the high tap enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_i | input | CODE_W | Latched wiper code |
| shutdown_i | input | 1 | Shutdown request, active high |
| tap_en_o | output | NUM_POS | One-hot tap switch enables; bit 0 is the B end |
| a_sw_en_o | output | 1 | Close the switch to the A terminal |
| wb_short_o | output | 1 | Short the wiper to the B terminal |
| pos_o | output | clog2(NUM_POS) | Effective tap index |

## Verification
The hardest situation to reach from the ports is a saturating code that is held during shutdown and is still present when shutdown is released. To pass, the first cycle out of shutdown must land on the top tap, and no trace of tap 0 may remain. Directed steps build this case: they hold codes such as 63 and 33 through shutdown and then release it, and they also switch the code in the same cycle as the release. Random steps then mix shutdown toggles with codes drawn over the whole 6-bit range. Because a large share of that range saturates, the random steps often hit the clamp boundary.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef struct packed {
    logic a_close;
    logic wb_short;
  } term_sw_t;

  localparam term_sw_t TERM_RUN  = '{a_close: 1'b1, wb_short: 1'b0};
  localparam term_sw_t TERM_SHDN = '{a_close: 1'b0, wb_short: 1'b1};
endpackage

// File: rtl/wiper_code_clamp.sv
module wiper_code_clamp #(
  parameter int CODE_W = 6,
  parameter int NUM_POS = 33,
  parameter int IDX_W = 6
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              sat_o
);
  localparam int TOP = NUM_POS - 1;

  function automatic logic [IDX_W-1:0] clamp_pos(input logic [CODE_W-1:0] c);
    if (int'(c) >= TOP) return IDX_W'(TOP);
    return IDX_W'(c);
  endfunction

  function automatic logic is_sat(input logic [CODE_W-1:0] c);
    return int'(c) >= TOP;
  endfunction

  assign idx_o = clamp_pos(code_i);
  assign sat_o = is_sat(code_i);
endmodule

// File: rtl/wiper_tap_onehot.sv
module wiper_tap_onehot #(
  parameter int NUM_POS = 33,
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0]   idx_i,
  output logic [NUM_POS-1:0] onehot_o
);
  for (genvar g = 0; g < NUM_POS; g++) begin : g_tap
    assign onehot_o[g] = (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/wiper_tap_switch_dec.sv
module wiper_tap_switch_dec
  import wiper_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int NUM_POS = 33
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CODE_W-1:0]        code_i,
  input  logic                     shutdown_i,
  output logic [NUM_POS-1:0]       tap_en_o,
  output logic                     a_sw_en_o,
  output logic                     wb_short_o,
  output logic [((NUM_POS > 1) ? $clog2(NUM_POS) : 1)-1:0] pos_o
);
  localparam int IDX_W = (NUM_POS > 1) ? $clog2(NUM_POS) : 1;

  // Internal events brought out as named wires
  logic [IDX_W-1:0]   clamp_idx;
  logic               clamp_sat;
  logic [IDX_W-1:0]   sel_idx;
  logic [NUM_POS-1:0] sel_onehot;
  term_sw_t           term_nxt;
  term_sw_t           term_q;
  logic [NUM_POS-1:0] tap_q;
  logic [IDX_W-1:0]   pos_q;

  wiper_code_clamp #(.CODE_W(CODE_W), .NUM_POS(NUM_POS), .IDX_W(IDX_W)) clamp_i (
    .code_i (code_i),
    .idx_o  (clamp_idx),
    .sat_o  (clamp_sat)
  );

  assign sel_idx  = shutdown_i ? '0 : clamp_idx;
  assign term_nxt = shutdown_i ? TERM_SHDN : TERM_RUN;

  wiper_tap_onehot #(.NUM_POS(NUM_POS), .IDX_W(IDX_W)) onehot_i (
    .idx_i    (sel_idx),
    .onehot_o (sel_onehot)
  );

  // Single register stage: every switch enable moves on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q  <= NUM_POS'(1);
      term_q <= TERM_SHDN;
      pos_q  <= '0;
    end else begin
      tap_q  <= sel_onehot;
      term_q <= term_nxt;
      pos_q  <= sel_idx;
    end
  end

  assign tap_en_o   = tap_q;
  assign a_sw_en_o  = term_q.a_close;
  assign wb_short_o = term_q.wb_short;
  assign pos_o      = pos_q;

  assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_en_o) == 1);

  assert_pos_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tap_en_o[pos_o] == 1'b1);

  assert_shdn_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> (tap_en_o[0] && !a_sw_en_o && wb_short_o && pos_o == '0));

  assert_run_terms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown_i |=> (a_sw_en_o && !wb_short_o));

  assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown_i && clamp_sat) |=> (pos_o == IDX_W'(NUM_POS - 1)));

  assert_follow_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown_i && !clamp_sat) |=> (pos_o == IDX_W'($past(code_i))));

  assert_clamp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(clamp_idx) <= NUM_POS - 1);
endmodule

// File: tb/wiper_tap_switch_dec_tb.sv
module wiper_tap_switch_dec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;
  localparam int NP = 33;
  localparam int IW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] code = '0;
  logic          shdn = 1'b0;
  logic [NP-1:0] tap_en;
  logic          a_en;
  logic          wb_sh;
  logic [IW-1:0] pos;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_tap_switch_dec #(.CODE_W(CW), .NUM_POS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .code_i(code), .shutdown_i(shdn),
    .tap_en_o(tap_en), .a_sw_en_o(a_en), .wb_short_o(wb_sh), .pos_o(pos)
  );

  function automatic int want_pos(input int c, input bit s);
    if (s) return 0;
    return (c > NP - 1) ? NP - 1 : c;
  endfunction

  task automatic expect_state(input string tag, input int p, input bit s);
    logic [NP-1:0] ev;
    ev = '0;
    ev[p] = 1'b1;
    checks++;
    if (tap_en !== ev || pos !== IW'(p) || a_en !== !s || wb_sh !== s) begin
      errors++;
      $display("FAIL %s: tap=%h pos=%0d a=%b sh=%b expected tap=%h pos=%0d a=%b sh=%b",
               tag, tap_en, pos, a_en, wb_sh, ev, p, !s, s);
    end
  endtask

  task automatic step(input string tag, input int c, input bit s);
    @(negedge clk);
    code = CW'(c);
    shdn = s;
    @(negedge clk);
    expect_state(tag, want_pos(c, s), s);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    int prev_pos;
    seed = 32'h5eed1;
    void'($urandom(seed));
    code = 6'd20;
    repeat (3) @(negedge clk);
    expect_state("R1 reset state", 0, 1'b1);
    rst_n = 1'b1;
    #1;
    expect_state("R1 before first edge", 0, 1'b1);

    step("R2 code 0", 0, 0);
    step("R2 code 1", 1, 0);
    step("R2 code 16", 16, 0);
    step("R2 code 31", 31, 0);
    step("R3 code 32 top", 32, 0);
    step("R3 code 33", 33, 0);
    step("R3 code 63", 63, 0);

    // R8: new input has no effect before the next edge
    @(negedge clk);
    code = 6'd5;
    #1;
    expect_state("R8 held before edge", NP - 1, 0);
    @(negedge clk);
    expect_state("R8 all update together", 5, 0);

    step("R4 shutdown code 63", 63, 1);
    step("R4 shutdown code 12", 12, 1);
    step("R7 release saturating", 63, 0);
    step("R4 shutdown code 33", 33, 1);
    @(negedge clk);
    code = 6'd9;
    shdn = 1'b0;
    @(negedge clk);
    expect_state("R7 release new code", 9, 0);
    step("R5 run terms", 40, 0);

    prev_pos = NP - 1;
    for (int i = 0; i < 300; i++) begin
      int c;
      bit s;
      c = int'($urandom_range(63, 0));
      s = ($urandom_range(3, 0) == 0);
      step((s ? "R4 random shutdown" : (c >= NP - 1 ? "R3 random clamp" : "R2 random code")), c, s);
      checks++;
      if ($countones(tap_en) != 1 || tap_en[pos] !== 1'b1) begin
        errors++;
        $display("FAIL R6 R9 onehot/pos: tap=%h pos=%0d expected single bit at pos", tap_en, pos);
      end
      prev_pos = int'(pos);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule